// File: doc/BRIEF.md
# Zone Bitmap Stride Prefetcher

This block watches the stream of demand line addresses from a cache and predicts which lines will be needed next. Memory is cut into equal zones of cache lines. For each recently touched zone it keeps one 2-bit state per line, so it remembers which lines were demanded, which were fetched ahead, and which fetched-ahead lines were later demanded. Strides are found from this bitmap and not from the order of the accesses. A burst of accesses that arrives shuffled, or loop code that was unrolled, still shows the same stride.

On each accepted access, the block updates the line's state. It then tests every forward stride at once. Line t+s becomes a candidate when lines t-s and t-2s have both been used and t+s has not been touched. Up to a set number of candidates go out one at a time on a valid/ready prefetch port, smallest stride first. New accesses are held off while that port is busy. Zone maps live in a small fully associative table with least-recently-used replacement.

Top module: `ampm_prefetch`

## Requirements
- R1: After reset `pf_valid` is 0, `acc_ready` is 1, and no zone is tracked, so the first access to any zone issues no prefetch.
- R2: Each line has a 2-bit state: untouched = 0, seen = 1, fetched = 2, confirmed = 3. A demand access moves an untouched line to seen and a fetched line to confirmed. Seen and confirmed lines count as used.
- R3: For an access at zone offset t, stride s (1 to STRIDES) yields candidate line t+s when lines t-s and t-2s are both used and line t+s is untouched.
- R4: No more than MAX_ISSUE (default 2) prefetches follow one access, in increasing stride order.
- R5: A prefetched line enters the fetched state when its handshake completes and is never proposed again while its zone stays tracked.
- R6: Detection depends only on the set of lines used, not on the order in which they were accessed.
- R7: An access to an untracked zone takes over the least recently used of ZONES map slots and starts it with every line untouched except the accessed one, which is seen. The evicted zone's history is lost.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_line` hold. `acc_ready` is low whenever `pf_valid` is high.
- R9: A prefetch address always stays inside the zone of its access. Candidates that would fall outside the zone, or need history from outside it, are dropped.
- R10: The first prefetch for an access is valid in the cycle right after the edge that accepted the access. Each further one follows the cycle after the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Block can take an access |
| acc_line | input | LINE_W | Demand line address |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Prefetch request taken |
| pf_line | output | LINE_W | Prefetch line address |

## Verification
Every cycle, the assertions check the port rules:
- a stalled prefetch holds,
- no access is taken while a prefetch is pending,
- a prefetch only follows an accepted access,
- the per-access cap,
- that a prefetch always marks an untouched line ahead of the access,
- that a tag is never held by two slots.

Other behaviours can only be shown by the bench's scenarios:
- the stride rule,
- smallest-stride ordering,
- independence from access order,
- zone-edge clipping,
- LRU eviction and its loss of history.

For these, a reference model of the zone table and line states is compared with the design across directed and random streams, with random back-pressure.

// File: rtl/ampm_pkg.sv
package ampm_pkg;

  typedef enum logic [1:0] {
    LS_IDLE    = 2'd0,
    LS_SEEN    = 2'd1,
    LS_FETCHED = 2'd2,
    LS_CONFIRM = 2'd3
  } line_st_e;

  function automatic logic is_used(input logic [1:0] st);
    return (st == LS_SEEN) || (st == LS_CONFIRM);
  endfunction

endpackage

// File: rtl/ampm_zone_dir.sv
module ampm_zone_dir #(
  parameter int TAG_W = 26,
  parameter int ZONES = 8,
  localparam int WAY_W = $clog2(ZONES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             alloc_en
);

  logic [TAG_W-1:0] tag_q [ZONES];
  logic [ZONES-1:0] vld_q;
  logic [WAY_W-1:0] age_q [ZONES];
  logic [ZONES-1:0] hit_vec;

  for (genvar g = 0; g < ZONES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way    = '0;
    victim_way = '0;
    for (int i = 0; i < ZONES; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
      if (age_q[i] == WAY_W'(ZONES - 1)) victim_way = WAY_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < ZONES; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ZONES; i++) begin
        if (WAY_W'(i) == touch_way) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way]) age_q[i] <= age_q[i] + 1'b1;
      end
      if (alloc_en) begin
        tag_q[touch_way] <= lk_tag;
        vld_q[touch_way] <= 1'b1;
      end
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R7

  AST_VICTIM_OLDEST: assert property (@(posedge clk) disable iff (rst)
    touch_en && alloc_en |-> touch_way == victim_way); // R7

endmodule

// File: rtl/ampm_map_store.sv
module ampm_map_store #(
  parameter int ZONES = 8,
  parameter int LINES = 64,
  localparam int WAY_W = $clog2(ZONES),
  localparam int OFF_W = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic [WAY_W-1:0]      rd_way,
  output logic [LINES-1:0][1:0] rd_row,
  input  logic                  clr_en,
  input  logic                  wr_en,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [OFF_W-1:0]      wr_off,
  input  logic [1:0]            wr_st
);

  logic [LINES-1:0][1:0] map_q [ZONES];

  assign rd_row = map_q[rd_way];

  always_ff @(posedge clk) begin
    if (clr_en) map_q[wr_way] <= '0;
    if (wr_en)  map_q[wr_way][wr_off] <= wr_st;
  end

endmodule

// File: rtl/ampm_match.sv
module ampm_match
  import ampm_pkg::*;
#(
  parameter int LINES   = 64,
  parameter int STRIDES = 8,
  localparam int OFF_W = $clog2(LINES)
) (
  input  logic [LINES-1:0][1:0] row,
  input  logic [OFF_W-1:0]      t,
  output logic [STRIDES-1:0]    cand
);

  localparam logic [OFF_W:0] LIM = (OFF_W + 1)'(LINES);

  logic [OFF_W:0] ext;
  assign ext = {1'b0, t};

  for (genvar g = 0; g < STRIDES; g++) begin : g_stride
    localparam logic [OFF_W:0] S1 = (OFF_W + 1)'(g + 1);
    localparam logic [OFF_W:0] S2 = (OFF_W + 1)'(2 * (g + 1));
    logic [OFF_W:0] lo1, lo2, hi;
    assign lo1 = ext - S1;
    assign lo2 = ext - S2;
    assign hi  = ext + S1;
    always_comb begin
      cand[g] = 1'b0;
      if (ext >= S2 && hi < LIM)
        cand[g] = is_used(row[lo1[OFF_W-1:0]]) && is_used(row[lo2[OFF_W-1:0]]) &&
                  (row[hi[OFF_W-1:0]] == LS_IDLE);
    end
  end

endmodule

// File: rtl/ampm_prefetch.sv
module ampm_prefetch
  import ampm_pkg::*;
#(
  parameter int LINE_W     = 32,
  parameter int ZONE_LINES = 64,
  parameter int ZONES      = 8,
  parameter int STRIDES    = 8,
  parameter int MAX_ISSUE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [LINE_W-1:0] acc_line,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);

  localparam int OFF_W  = $clog2(ZONE_LINES);
  localparam int TAG_W  = LINE_W - OFF_W;
  localparam int WAY_W  = $clog2(ZONES);
  localparam int CNT_W  = $clog2(MAX_ISSUE + 1);
  localparam int SIDX_W = (STRIDES > 1) ? $clog2(STRIDES) : 1;

  logic                  busy_q;
  logic [TAG_W-1:0]      tag_q;
  logic [WAY_W-1:0]      way_q;
  logic [OFF_W-1:0]      off_q;
  logic [STRIDES-1:0]    rem_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [LINE_W-1:0]     pf_line_q;

  logic [TAG_W-1:0]      lk_tag;
  logic [OFF_W-1:0]      t;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, victim_way, sel_way, rd_way;
  logic [ZONE_LINES-1:0][1:0] row;
  logic [STRIDES-1:0]    match_c, cand;
  logic                  acc_fire, pf_fire;
  logic [1:0]            cur_st, new_st, wr_st;
  logic                  wr_en;
  logic [WAY_W-1:0]      wr_way;
  logic [OFF_W-1:0]      wr_off, pf_off;

  function automatic logic [SIDX_W-1:0] pick_low(input logic [STRIDES-1:0] m);
    pick_low = '0;
    for (int i = STRIDES - 1; i >= 0; i--)
      if (m[i]) pick_low = SIDX_W'(i);
  endfunction

  function automatic logic [LINE_W-1:0] mk_line(input logic [TAG_W-1:0] tg,
                                                input logic [OFF_W-1:0] o,
                                                input logic [SIDX_W-1:0] idx);
    logic [OFF_W-1:0] n;
    n = o + OFF_W'(idx) + OFF_W'(1);
    return {tg, n};
  endfunction

  assign lk_tag    = acc_line[LINE_W-1:OFF_W];
  assign t         = acc_line[OFF_W-1:0];
  assign acc_ready = !busy_q;
  assign acc_fire  = acc_valid && !busy_q;
  assign pf_valid  = busy_q;
  assign pf_line   = pf_line_q;
  assign pf_fire   = busy_q && pf_ready;
  assign pf_off    = pf_line_q[OFF_W-1:0];
  assign sel_way   = hit ? hit_way : victim_way;
  assign rd_way    = busy_q ? way_q : sel_way;

  ampm_zone_dir #(.TAG_W(TAG_W), .ZONES(ZONES)) u_dir (
    .clk        (clk),
    .rst        (rst),
    .lk_tag     (lk_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way),
    .touch_en   (acc_fire),
    .touch_way  (sel_way),
    .alloc_en   (acc_fire && !hit)
  );

  ampm_map_store #(.ZONES(ZONES), .LINES(ZONE_LINES)) u_map (
    .clk    (clk),
    .rd_way (rd_way),
    .rd_row (row),
    .clr_en (acc_fire && !hit),
    .wr_en  (wr_en),
    .wr_way (wr_way),
    .wr_off (wr_off),
    .wr_st  (wr_st)
  );

  ampm_match #(.LINES(ZONE_LINES), .STRIDES(STRIDES)) u_match (
    .row  (row),
    .t    (t),
    .cand (match_c)
  );

  assign cand   = hit ? match_c : '0;
  assign cur_st = row[t];

  always_comb begin
    case (cur_st)
      LS_IDLE:    new_st = LS_SEEN;
      LS_FETCHED: new_st = LS_CONFIRM;
      default:    new_st = cur_st;
    endcase
    if (!hit) new_st = LS_SEEN;
  end

  assign wr_en  = acc_fire || pf_fire;
  assign wr_way = acc_fire ? sel_way : way_q;
  assign wr_off = acc_fire ? t : pf_off;
  assign wr_st  = acc_fire ? new_st : LS_FETCHED;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      rem_q     <= '0;
      cnt_q     <= '0;
      pf_line_q <= '0;
      tag_q     <= '0;
      way_q     <= '0;
      off_q     <= '0;
    end else if (acc_fire) begin
      tag_q <= lk_tag;
      way_q <= sel_way;
      off_q <= t;
      if (cand != '0) begin
        busy_q    <= 1'b1;
        pf_line_q <= mk_line(lk_tag, t, pick_low(cand));
        rem_q     <= cand & ~(STRIDES'(1) << pick_low(cand));
        cnt_q     <= CNT_W'(1);
      end
    end else if (pf_fire) begin
      if (rem_q != '0 && cnt_q < CNT_W'(MAX_ISSUE)) begin
        pf_line_q <= mk_line(tag_q, off_q, pick_low(rem_q));
        rem_q     <= rem_q & ~(STRIDES'(1) << pick_low(rem_q));
        cnt_q     <= cnt_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line)); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !acc_ready); // R8

  AST_PF_CAP: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_ISSUE))); // R4

  AST_PF_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    pf_fire |-> row[pf_off] == LS_IDLE); // R5

  AST_PF_AHEAD: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_line[OFF_W-1:0] > off_q); // R9

  AST_PF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_valid) |-> $past(acc_valid && acc_ready)); // R10

endmodule

// File: tb/ampm_prefetch_bench.sv
module ampm_prefetch_bench;

  localparam int CLK_P = 10;
  localparam int LW = 32;
  localparam int ZL = 64;
  localparam int NZ = 8;
  localparam int NS = 8;
  localparam int MI = 2;

  logic clk = 0;
  logic rst = 1;
  logic acc_valid = 0;
  logic [LW-1:0] acc_line = '0;
  logic pf_ready = 0;
  logic acc_ready, pf_valid;
  logic [LW-1:0] pf_line;

  int errors = 0;
  int checks = 0;
  bit bp_on = 0;
  bit finished = 0;

  int m_tag [NZ];
  bit m_vld [NZ];
  int m_use [NZ];
  int m_map [NZ][ZL];
  int use_ctr = 0;
  int exp_n;
  int exp_l [MI];

  always #(CLK_P/2) clk = ~clk;

  ampm_prefetch u_ampm_prefetch (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_line(acc_line), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit used(input int s);
    return s == 1 || s == 3;
  endfunction

  // reference model: computes expected prefetches, then updates states
  function automatic void model_access(input int line);
    int tg, t, z;
    tg = line / ZL;
    t  = line % ZL;
    z  = -1;
    exp_n = 0;
    use_ctr++;
    for (int i = 0; i < NZ; i++) if (m_vld[i] && m_tag[i] == tg) z = i;
    if (z < 0) begin
      int best;
      best = -1;
      for (int i = 0; i < NZ; i++)
        if (best < 0 && !m_vld[i]) best = i;
      if (best < 0) begin
        best = 0;
        for (int i = 1; i < NZ; i++) if (m_use[i] < m_use[best]) best = i;
      end
      z = best;
      m_vld[z] = 1;
      m_tag[z] = tg;
      for (int k = 0; k < ZL; k++) m_map[z][k] = 0;
      m_map[z][t] = 1;
    end else begin
      for (int s = 1; s <= NS; s++)
        if (exp_n < MI && t - 2*s >= 0 && t + s < ZL &&
            used(m_map[z][t-s]) && used(m_map[z][t-2*s]) && m_map[z][t+s] == 0) begin
          exp_l[exp_n] = tg * ZL + t + s;
          exp_n++;
        end
      if (m_map[z][t] == 0) m_map[z][t] = 1;
      else if (m_map[z][t] == 2) m_map[z][t] = 3;
      for (int k = 0; k < exp_n; k++) m_map[z][exp_l[k] % ZL] = 2;
    end
    m_use[z] = use_ctr;
  endfunction

  task automatic do_access(input int line, input string req);
    @(negedge clk);
    chk(acc_ready == 1'b1, req, "acc_ready before access", acc_ready, 1);
    acc_valid = 1;
    acc_line  = LW'(line);
    model_access(line);
    @(negedge clk);
    acc_valid = 0;
    for (int k = 0; k < exp_n; k++) begin
      bit go;
      go = 0;
      while (!go) begin
        chk(pf_valid == 1'b1, req, "pf_valid", pf_valid, 1);
        chk(pf_line == LW'(exp_l[k]), req, "pf_line", pf_line, exp_l[k]);
        chk(acc_ready == 1'b0, "R8", "acc_ready while issuing", acc_ready, 0);
        go = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
        pf_ready = go;
        @(negedge clk);
      end
    end
    pf_ready = 0;
    chk(pf_valid == 1'b0, req, "pf_valid after burst", pf_valid, 0);
    chk(acc_ready == 1'b1, req, "acc_ready after burst", acc_ready, 1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20240601));
    for (int i = 0; i < NZ; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", pf_valid, 0);
    chk(acc_ready == 1'b1, "R1", "acc_ready after reset", acc_ready, 1);
    do_access(5 * ZL + 20, "R1");

    // R3, R2: sequential stride 1 then demand of prefetched line
    base = 10 * ZL;
    do_access(base + 0, "R3");
    do_access(base + 1, "R3");
    do_access(base + 2, "R3");
    chk(exp_n == 1 && exp_l[0] == base + 3, "R3", "model expects line 3", exp_l[0], base + 3);
    do_access(base + 3, "R2");

    // R6: out of order stride 2
    base = 11 * ZL;
    do_access(base + 6, "R6");
    do_access(base + 2, "R6");
    do_access(base + 4, "R6");
    do_access(base + 8, "R6");
    chk(exp_n == 1 && exp_l[0] == base + 10, "R6", "model expects line 10", exp_l[0], base + 10);

    // R4: dense even pattern, several strides qualify
    base = 12 * ZL;
    for (int k = 0; k <= 16; k += 2) do_access(base + k, "R4");
    for (int k = 30; k >= 20; k -= 2) do_access(base + k, "R4");

    // R9 and R5: zone edge and no re-prefetch
    base = 13 * ZL;
    do_access(base + 60, "R9");
    do_access(base + 61, "R9");
    do_access(base + 62, "R9");
    do_access(base + 63, "R9");
    do_access(base + 62, "R5");
    do_access(base + 61, "R5");

    // R7: fill table with new zones, then the oldest zone has lost history
    base = 20 * ZL;
    do_access(base + 0, "R7");
    do_access(base + 1, "R7");
    for (int z = 0; z < NZ; z++) do_access((30 + z) * ZL + 5, "R7");
    do_access(base + 2, "R7");
    chk(exp_n == 0, "R7", "evicted zone issues nothing", exp_n, 0);

    // R8: back-pressure with random stream
    bp_on = 1;
    for (int n = 0; n < 400; n++) begin
      int z, o;
      z = 40 + $urandom_range(0, 9);
      o = $urandom_range(0, ZL - 1);
      do_access(z * ZL + o, "R8");
    end
    for (int n = 0; n < 200; n++) begin
      int o;
      o = (n * 3) % ZL;
      do_access((60 + n / 20) * ZL + o, "R10");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule